// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block takes an asynchronous DRAM from power-up to a refreshed, usable state and then keeps it refreshed. It first waits out a power-on pause with every strobe inactive. It then runs a fixed number of wake-up cycles, each with the CAS strobes falling before RAS. After that it raises the ready flag for a separate access controller. From then on it counts a refresh interval. Each time the interval expires it owes the memory one refresh, and it asks the access controller for the strobes with a request/grant handshake.

Refreshes use CAS-before-RAS ordering, so the device supplies the row address and the block has no address output. Owed refreshes may pile up to a limit while the access controller is busy. At the limit the block flags them as urgent. If one more interval expires on top of that, the refresh deadline is treated as missed: ready drops and the wake-up cycles run again. On request the block parks the device in self-refresh by holding both strobes low. When released, it observes a long precharge before it becomes ready again.

All timing limits are given in nanoseconds together with the clock period. They are turned into whole clock cycles when the design is built, always rounding up.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, RAS and every CAS lane stay high and memReady stays low for exactly ceil(PWRUP_NS/period) cycles.
- R2: After the pause the block runs exactly WAKE_CYCLES strobe cycles with memReady low. memReady rises in the cycle after the last precharge cycle. refReq stays low throughout.
- R3: Every strobe cycle takes the same three steps: all CAS lanes low with RAS high for ceil(CAS_SETUP_NS/period) cycles; then RAS low with CAS still low for max(ceil(RAS_LOW_NS/period), ceil(CAS_HOLD_NS/period)) cycles; then both high for ceil(RAS_PRE_NS/period) cycles. With a 4 ns clock and the bench limits these are 2, 15 and 10 cycles.
- R4: While memReady is high, one refresh becomes owed every ceil(REFI_NS/period) cycles, counted from the first ready cycle. refReq is high in every idle cycle in which at least one refresh is owed, and in every cycle of a refresh.
- R5: A refresh starts only after the block sees refGrant high in an idle cycle with refReq high. While the grant is withheld, RAS and CAS stay high.
- R6: refDone is high for one cycle, the last precharge cycle of a refresh. That refresh then counts as paid. If more are owed and the grant is still high, the next refresh starts one idle cycle later.
- R7: refUrgent is high exactly while memReady is high and MAX_POSTPONE refreshes are owed.
- R8: If an interval expires while MAX_POSTPONE refreshes are already owed, memReady falls in the following cycle and the full wake-up sequence of R2 runs again. After it, nothing is owed.
- R9: When selfReq is seen high in an idle cycle, the block drops memReady and drives CAS low for the setup time, then RAS low. RAS stays low for at least ceil(SELF_MIN_NS/period) cycles and for as long as selfReq stays high.
- R10: On leaving self-refresh, RAS and CAS stay high for ceil(SELF_EXIT_NS/period) cycles. memReady then returns with nothing owed, and the interval restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refGrant | input | 1 | Access controller yields the strobes for a refresh |
| selfReq | input | 1 | Level request to hold the device in self-refresh |
| rasN | output | 1 | Row strobe, active low |
| casN | output | CAS_LANES | Column strobes (one per byte lane), active low |
| refReq | output | 1 | Refresh owed or in progress |
| refDone | output | 1 | One-cycle pulse ending a refresh |
| refUrgent | output | 1 | Postponement limit reached |
| memReady | output | 1 | Device initialized and available for access |

## Verification
The hardest state to reach from the ports is the missed deadline. It needs the postponement limit filled and one more interval to expire, all while no grant is given. The bench withholds refGrant for nine full intervals after a pair of back-to-back granted refreshes has drained the count. It then expects urgency from the eighth interval and a complete second wake-up sequence right after the ninth. Self-refresh is driven twice, once released before the minimum low time and once held past it, so both exit conditions are exercised.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP, ST_IDLE, ST_CSR, ST_RASLO, ST_PRE, ST_SELF, ST_SEXIT
  } seq_state_e;

  typedef enum logic [1:0] {MD_WAKE, MD_REF, MD_SELF} cyc_mode_e;

  typedef enum logic [2:0] {
    PH_PWR, PH_CSR, PH_RAS, PH_PRE, PH_SELF, PH_SEXIT
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic   tmrLoad;
    phase_e tmrSel;
    logic   wakeClr;
    logic   wakeInc;
    logic   pendDec;
    logic   run;
  } seq_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic tmrZero;
    logic wakeLast;
    logic pendNz;
    logic pendFull;
    logic missed;
  } seq_status_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns2cyc(input longint ns, input longint periodPs);
    longint c;
    c = (ns * 1000 + periodPs - 1) / periodPs;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/dram_refresh_dp.sv
module dram_refresh_dp
  import dram_refresh_pkg::*;
#(
  parameter int PWR_C    = 50000,
  parameter int CSR_C    = 2,
  parameter int RAS_C    = 15,
  parameter int PRE_C    = 10,
  parameter int SELF_C   = 25000,
  parameter int SEXIT_C  = 26,
  parameter int REFI_C   = 3900,
  parameter int WAKE_N   = 8,
  parameter int MAX_PEND = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t strb,
  output seq_status_t sts
);

  localparam int MAX_A  = (PWR_C > SELF_C) ? PWR_C : SELF_C;
  localparam int MAX_B  = (RAS_C > SEXIT_C) ? RAS_C : SEXIT_C;
  localparam int MAX_L  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W  = $clog2(MAX_L + 1);
  localparam int WK_W   = $clog2(WAKE_N + 1);
  localparam int PEND_W = $clog2(MAX_PEND + 1);
  localparam int IV_W   = $clog2(REFI_C + 1);

  localparam logic [TMR_W-1:0] LEN_PWR   = TMR_W'(PWR_C - 1);
  localparam logic [TMR_W-1:0] LEN_CSR   = TMR_W'(CSR_C - 1);
  localparam logic [TMR_W-1:0] LEN_RAS   = TMR_W'(RAS_C - 1);
  localparam logic [TMR_W-1:0] LEN_PRE   = TMR_W'(PRE_C - 1);
  localparam logic [TMR_W-1:0] LEN_SELF  = TMR_W'(SELF_C - 1);
  localparam logic [TMR_W-1:0] LEN_SEXIT = TMR_W'(SEXIT_C - 1);
  localparam logic [WK_W-1:0]  WAKE_LAST = WK_W'(WAKE_N - 1);
  localparam logic [PEND_W-1:0] PEND_MAX = PEND_W'(MAX_PEND);
  localparam logic [IV_W-1:0]  IV_LAST   = IV_W'(REFI_C - 1);

  // phase timer
  logic [TMR_W-1:0] tmrCnt, tmrLen;

  always_comb begin
    case (strb.tmrSel)
      PH_PWR:  tmrLen = LEN_PWR;
      PH_CSR:  tmrLen = LEN_CSR;
      PH_RAS:  tmrLen = LEN_RAS;
      PH_PRE:  tmrLen = LEN_PRE;
      PH_SELF: tmrLen = LEN_SELF;
      default: tmrLen = LEN_SEXIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tmrCnt <= LEN_PWR;
    else if (strb.tmrLoad)    tmrCnt <= tmrLen;
    else if (tmrCnt != '0)    tmrCnt <= tmrCnt - 1'b1;
  end

  // wake-up cycle counter
  logic [WK_W-1:0] wakeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wakeCnt <= '0;
    else if (strb.wakeClr) wakeCnt <= '0;
    else if (strb.wakeInc) wakeCnt <= wakeCnt + 1'b1;
  end

  // refresh interval and owed-refresh count
  logic [IV_W-1:0]   ivCnt;
  logic [PEND_W-1:0] pendCnt;
  logic              missed;
  logic              ivTick;

  assign ivTick = (ivCnt == IV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ivCnt   <= '0;
      pendCnt <= '0;
      missed  <= 1'b0;
    end else if (!strb.run) begin
      ivCnt   <= '0;
      pendCnt <= '0;
      missed  <= 1'b0;
    end else begin
      ivCnt <= ivTick ? '0 : ivCnt + 1'b1;
      if (ivTick && !strb.pendDec) begin
        if (pendCnt == PEND_MAX) missed <= 1'b1;
        else                     pendCnt <= pendCnt + 1'b1;
      end else if (!ivTick && strb.pendDec && pendCnt != '0) begin
        pendCnt <= pendCnt - 1'b1;
      end
    end
  end

  assign sts.tmrZero  = (tmrCnt == '0);
  assign sts.wakeLast = (wakeCnt == WAKE_LAST);
  assign sts.pendNz   = (pendCnt != '0);
  assign sts.pendFull = (pendCnt == PEND_MAX);
  assign sts.missed   = missed;

  p_pend_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PEND_MAX);

  p_miss_from_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(missed) |-> $past(pendCnt) == PEND_MAX);

endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl
  import dram_refresh_pkg::*;
#(
  parameter int CAS_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refGrant,
  input  logic                 selfReq,
  input  seq_status_t          sts,
  output seq_strobe_t          strb,
  output logic                 rasN,
  output logic [CAS_LANES-1:0] casN,
  output logic                 refReq,
  output logic                 refDone,
  output logic                 refUrgent,
  output logic                 memReady
);

  seq_state_e state, nxtState;
  cyc_mode_e  mode, nxtMode;
  logic       rasReg, casReg;
  logic       refOwn;

  assign refOwn    = (mode == MD_REF) &&
                     (state == ST_CSR || state == ST_RASLO || state == ST_PRE);
  assign memReady  = (state == ST_IDLE) || refOwn;
  assign refReq    = ((state == ST_IDLE) && sts.pendNz) || refOwn;
  assign refDone   = refOwn && (state == ST_PRE) && sts.tmrZero;
  assign refUrgent = memReady && sts.pendFull;

  always_comb begin
    nxtState    = state;
    nxtMode     = mode;
    strb        = '0;
    strb.tmrSel = PH_CSR;
    strb.run    = memReady;
    case (state)
      ST_PWRUP: if (sts.tmrZero) begin
        nxtState = ST_CSR; nxtMode = MD_WAKE;
        strb.tmrLoad = 1'b1; strb.wakeClr = 1'b1;
      end
      ST_IDLE: begin
        if (sts.missed) begin
          nxtState = ST_CSR; nxtMode = MD_WAKE;
          strb.tmrLoad = 1'b1; strb.wakeClr = 1'b1;
        end else if (selfReq) begin
          nxtState = ST_CSR; nxtMode = MD_SELF; strb.tmrLoad = 1'b1;
        end else if (sts.pendNz && refGrant) begin
          nxtState = ST_CSR; nxtMode = MD_REF; strb.tmrLoad = 1'b1;
        end
      end
      ST_CSR: if (sts.tmrZero) begin
        strb.tmrLoad = 1'b1;
        if (mode == MD_SELF) begin
          nxtState = ST_SELF;  strb.tmrSel = PH_SELF;
        end else begin
          nxtState = ST_RASLO; strb.tmrSel = PH_RAS;
        end
      end
      ST_RASLO: if (sts.tmrZero) begin
        nxtState = ST_PRE; strb.tmrLoad = 1'b1; strb.tmrSel = PH_PRE;
      end
      ST_PRE: if (sts.tmrZero) begin
        if (mode == MD_WAKE && !sts.wakeLast) begin
          nxtState = ST_CSR; strb.tmrLoad = 1'b1; strb.wakeInc = 1'b1;
        end else begin
          nxtState = ST_IDLE;
          strb.pendDec = (mode == MD_REF);
        end
      end
      ST_SELF: if (sts.tmrZero && !selfReq) begin
        nxtState = ST_SEXIT; strb.tmrLoad = 1'b1; strb.tmrSel = PH_SEXIT;
      end
      ST_SEXIT: if (sts.tmrZero) nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_PWRUP;
      mode   <= MD_WAKE;
      rasReg <= 1'b1;
      casReg <= 1'b1;
    end else begin
      state  <= nxtState;
      mode   <= nxtMode;
      rasReg <= !(nxtState == ST_RASLO || nxtState == ST_SELF);
      casReg <= !(nxtState == ST_CSR || nxtState == ST_RASLO ||
                  nxtState == ST_SELF);
    end
  end

  assign rasN = rasReg;

  for (genvar g = 0; g < CAS_LANES; g++) begin : g_casLane
    assign casN[g] = casReg;
  end

  p_cas_lead_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasReg) |-> (!casReg && !$past(casReg)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    refDone |=> !refDone);

  p_own_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReady && !casReg) |-> refReq);

  p_urgent_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent |-> refReq);

  p_self_min_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SELF && !sts.tmrZero) |=> !rasReg);

  p_pwrup_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PWRUP) |-> (rasReg && casReg && !memReady));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int PWRUP_NS      = 200000,
  parameter int REFI_NS       = 15600,
  parameter int RAS_LOW_NS    = 60,
  parameter int RAS_PRE_NS    = 40,
  parameter int CAS_SETUP_NS  = 5,
  parameter int CAS_HOLD_NS   = 10,
  parameter int SELF_MIN_NS   = 100000,
  parameter int SELF_EXIT_NS  = 104,
  parameter int WAKE_CYCLES   = 8,
  parameter int MAX_POSTPONE  = 8,
  parameter int CAS_LANES     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refGrant,
  input  logic                 selfReq,
  output logic                 rasN,
  output logic [CAS_LANES-1:0] casN,
  output logic                 refReq,
  output logic                 refDone,
  output logic                 refUrgent,
  output logic                 memReady
);

  localparam int RAS_LO_C = ns2cyc(RAS_LOW_NS, CLK_PERIOD_PS);
  localparam int CHR_C    = ns2cyc(CAS_HOLD_NS, CLK_PERIOD_PS);

  seq_strobe_t strb;
  seq_status_t sts;

  dram_refresh_dp #(
    .PWR_C   (ns2cyc(PWRUP_NS, CLK_PERIOD_PS)),
    .CSR_C   (ns2cyc(CAS_SETUP_NS, CLK_PERIOD_PS)),
    .RAS_C   ((RAS_LO_C > CHR_C) ? RAS_LO_C : CHR_C),
    .PRE_C   (ns2cyc(RAS_PRE_NS, CLK_PERIOD_PS)),
    .SELF_C  (ns2cyc(SELF_MIN_NS, CLK_PERIOD_PS)),
    .SEXIT_C (ns2cyc(SELF_EXIT_NS, CLK_PERIOD_PS)),
    .REFI_C  (ns2cyc(REFI_NS, CLK_PERIOD_PS)),
    .WAKE_N  (WAKE_CYCLES),
    .MAX_PEND(MAX_POSTPONE)
  ) u_dp (
    .clk (clk),
    .rstN(rstN),
    .strb(strb),
    .sts (sts)
  );

  dram_refresh_ctl #(.CAS_LANES(CAS_LANES)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .refGrant (refGrant),
    .selfReq  (selfReq),
    .sts      (sts),
    .strb     (strb),
    .rasN     (rasN),
    .casN     (casN),
    .refReq   (refReq),
    .refDone  (refDone),
    .refUrgent(refUrgent),
    .memReady (memReady)
  );

endmodule

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;

  // cycle counts from the requirements at a 4 ns clock
  localparam int PWR_C  = 100;  // 400 ns
  localparam int CSR_C  = 2;    // 5 ns rounded up
  localparam int RAS_C  = 15;   // 60 ns
  localparam int PRE_C  = 10;   // 40 ns
  localparam int SELF_C = 50;   // 200 ns
  localparam int SEX_C  = 26;   // 104 ns
  localparam int REFI_C = 120;  // 480 ns
  localparam int WAKE_N = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refGrant = 1'b0;
  logic       selfReq = 1'b0;
  logic       rasN, refReq, refDone, refUrgent, memReady;
  logic [1:0] casN;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .CLK_PERIOD_PS(4000), .PWRUP_NS(400), .REFI_NS(480),
    .SELF_MIN_NS(200), .WAKE_CYCLES(8), .MAX_POSTPONE(8), .CAS_LANES(2)
  ) uut (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .selfReq(selfReq),
    .rasN(rasN), .casN(casN), .refReq(refReq), .refDone(refDone),
    .refUrgent(refUrgent), .memReady(memReady)
  );

  // compare all outputs against the model for one cycle
  task automatic chk(input logic r, input logic c, input logic rdy,
                     input logic rq, input logic dn, input logic ug,
                     input string tag);
    logic [6:0] act, exp;
    act = {rasN, casN, memReady, refReq, refDone, refUrgent};
    exp = {r, c, c, rdy, rq, dn, ug};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t {ras,cas,rdy,req,done,urg} actual=%b expected=%b",
               tag, $time, act, exp);
    end
  endtask

  task automatic run(input int n, input logic r, input logic c,
                     input logic rdy, input logic rq, input logic ug,
                     input string tag);
    for (int i = 0; i < n; i++) begin
      chk(r, c, rdy, rq, 1'b0, ug, tag);
      @(negedge clk);
    end
  endtask

  // one CAS-before-RAS cycle; isRef marks a granted refresh
  task automatic cbrCycle(input logic isRef, input string tag);
    run(CSR_C, 1'b1, 1'b0, isRef, isRef, 1'b0, tag);
    run(RAS_C, 1'b0, 1'b0, isRef, isRef, 1'b0, tag);
    run(PRE_C - 1, 1'b1, 1'b1, isRef, isRef, 1'b0, tag);
    chk(1'b1, 1'b1, isRef, isRef, isRef, 1'b0, isRef ? "R6 done" : tag);
    @(negedge clk);
  endtask

  task automatic wakeSeq(input string tag);
    for (int w = 0; w < WAKE_N; w++) cbrCycle(1'b0, tag);
  endtask

  task automatic idle(input int n, input logic rq, input logic ug, input string tag);
    run(n, 1'b1, 1'b1, 1'b1, rq, ug, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1 in reset");
    rstN = 1'b1;
    // R1 power-on pause
    run(PWR_C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1 pause");
    // R2 wake-up cycles with R3 strobe ordering
    wakeSeq("R2 R3 wake");
    // R4 first interval, nothing owed
    idle(REFI_C, 1'b0, 1'b0, "R4 quiet");
    // R5 owed but not granted: strobes stay high
    idle(130, 1'b1, 1'b0, "R5 no grant");
    refGrant = 1'b1;
    idle(1, 1'b1, 1'b0, "R5 grant seen");
    cbrCycle(1'b1, "R3 R4 refresh");
    idle(1, 1'b1, 1'b0, "R6 still owed");
    cbrCycle(1'b1, "R6 back to back");
    refGrant = 1'b0;
    idle(54, 1'b0, 1'b0, "R6 paid");
    // R7 accumulate to the limit, R8 overflow
    idle(7 * REFI_C, 1'b1, 1'b0, "R7 postponed");
    idle(REFI_C + 1, 1'b1, 1'b1, "R7 urgent");
    wakeSeq("R8 rewake");
    // R9/R10 self-refresh released early
    idle(9, 1'b0, 1'b0, "R8 nothing owed");
    selfReq = 1'b1;
    idle(1, 1'b0, 1'b0, "R9 request");
    run(CSR_C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 cas lead");
    run(10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 self low");
    selfReq = 1'b0;
    run(SELF_C - 10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 minimum low");
    run(SEX_C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10 exit precharge");
    // self-refresh held past the minimum
    idle(4, 1'b0, 1'b0, "R10 ready");
    selfReq = 1'b1;
    idle(1, 1'b0, 1'b0, "R9 request");
    run(CSR_C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 cas lead");
    run(70, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 held");
    selfReq = 1'b0;
    run(1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 last low");
    run(SEX_C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10 exit precharge");
    idle(REFI_C, 1'b0, 1'b0, "R10 interval restarted");
    idle(2, 1'b1, 1'b0, "R4 owed again");
    summary();
  end

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

endmodule